// File: doc/BRIEF.md
# Configurable Look-Up Table Logic Cell

This block is a single programmable cell for a small SRAM-configured logic fabric. Its four data inputs address a 16-entry truth table, so the cell can produce any Boolean function of four variables on its combinational output. A carry stage lets a row of cells be chained into adders. A flip-flop with a synchronous set/reset option drives the registered output. When RAM mode is chosen, the same 16 table bits act as a 16x1 memory. The memory is written on the clock edge and read without waiting for a clock.

All 31 configuration bits live in one serial chain. The chain is loaded one bit per clock while the shift enable is high, least significant bit first. The bit shifted in first ends up at position 0. The serial output shows position 0, so a neighbouring cell can be daisy-chained behind this one. User logic uses the configuration bits as they stand at each moment, including while the chain is shifting.

Top module: `lut_logic_block`

## Requirements
- R1: While `rst_n` is low the configuration chain clears to all zeros and `yq` clears to 0. Just after reset, `y`, `carry_out`, `yq` and `cfg_sout` are all 0.
- R2: On each rising clock edge with `cfg_en` high, the chain moves one place towards bit 0 and `cfg_sin` enters bit 30. `cfg_sout` always shows bit 0. After 31 shifts, the value shifted in as bit i sits at position i. Shifting out then returns the bits in order from bit 0 upward.
- R3: With `cfg_en` low and no RAM write, the configuration chain keeps its value, whatever `cfg_sin` does.
- R4: With the carry bit (bit 17) clear, `y` equals the table bit at index `din`, where the table is configuration bits [15:0].
- R5: With bit 17 set, `y` = `din[0]` xor `din[1]` xor `carry_in`, and `carry_out` = majority(`din[0]`, `din[1]`, `carry_in`). With bit 17 clear, `carry_out` is 0.
- R6: With the RAM-mode bit (bit 16) set, `cfg_en` low and `wr_en` high, the clock edge writes `byp_d` into table bit `din`. The new value shows on `y` right after that edge. With bit 16 clear, `wr_en` has no effect.
- R7: Unless set/reset is active, `yq` takes `y` on each rising edge when bit 19 is 0, and takes `byp_d` when bit 19 is 1.
- R8: When `sr` is high, the edge loads `yq` with the value of bit 18 (1 = set, 0 = clear). This overrides the data selected in R7.
- R9: When `cfg_en` and a RAM write fall in the same cycle, the shift happens and the write is dropped.
- R10: A changed configuration bit affects `y` and `carry_out` right after the shift edge that changed it. No separate commit step is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register, RAM writes and configuration shifting |
| rst_n | input | 1 | Active-low reset |
| din | input | 4 | Table index / logic inputs; bits 0 and 1 are the carry operands |
| carry_in | input | 1 | Carry from the previous cell |
| sr | input | 1 | Synchronous set/reset request |
| wr_en | input | 1 | RAM write enable |
| byp_d | input | 1 | Direct data: RAM write data and alternative register input |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_sin | input | 1 | Configuration serial data in |
| cfg_sout | output | 1 | Configuration serial data out (bit 0) |
| y | output | 1 | Combinational output |
| yq | output | 1 | Registered output |
| carry_out | output | 1 | Carry to the next cell |

## Verification
The hardest case to reach from the ports is a RAM write that lands in the same cycle as a configuration shift. The dropped write can only be seen by draining the whole chain afterwards. The bench fills the table through RAM writes, then raises `cfg_en` and `wr_en` together with opposing data. It then shifts all 31 bits out and compares them with its own shift model. The chain's contents are also followed during every load, because `y` is checked after each single shift edge against the partially loaded table.

// File: rtl/lutblk_pkg.sv
package lutblk_pkg;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic sum3(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

endpackage

// File: rtl/lutblk_cfg_chain.sv
module lutblk_cfg_chain #(
  parameter int CFG_BITS = 31,
  parameter int IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                shift_in,
  input  logic                wr_req,
  input  logic [IDX_W-1:0]    wr_addr,
  input  logic                wr_data,
  output logic [CFG_BITS-1:0] cfg_q,
  output logic                shift_out
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (shift_en) begin
      cfg_q <= {shift_in, cfg_q[CFG_BITS-1:1]};
    end else if (wr_req) begin
      cfg_q[wr_addr] <= wr_data;
    end
  end

  assign shift_out = cfg_q[0];

endmodule

// File: rtl/lutblk_func.sv
module lutblk_func #(
  parameter int IDX_W = 4,
  localparam int TBL  = 1 << IDX_W
) (
  input  logic [TBL-1:0]   table_bits,
  input  logic [IDX_W-1:0] sel,
  input  logic             carry_en,
  input  logic             cin,
  output logic             y,
  output logic             cout
);
  import lutblk_pkg::*;

  logic lut_out;
  assign lut_out = table_bits[sel];

  always_comb begin
    if (carry_en) begin
      y    = sum3(sel[0], sel[1], cin);
      cout = maj3(sel[0], sel[1], cin);
    end else begin
      y    = lut_out;
      cout = 1'b0;
    end
  end

endmodule

// File: rtl/lutblk_ff.sv
module lutblk_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic sr,
  input  logic sr_val,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= 1'b0;
    else if (sr) q <= sr_val;
    else         q <= d;
  end

endmodule

// File: rtl/lut_logic_block.sv
module lut_logic_block #(
  parameter int IDX_W    = 4,
  parameter int CFG_BITS = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] din,
  input  logic             carry_in,
  input  logic             sr,
  input  logic             wr_en,
  input  logic             byp_d,
  input  logic             cfg_en,
  input  logic             cfg_sin,
  output logic             cfg_sout,
  output logic             y,
  output logic             yq,
  output logic             carry_out
);

  localparam int TBL     = 1 << IDX_W;
  localparam int RAM_BIT = TBL;
  localparam int CY_BIT  = TBL + 1;
  localparam int POL_BIT = TBL + 2;
  localparam int SRC_BIT = TBL + 3;

  logic [CFG_BITS-1:0] cfg_q;
  logic                ram_mode, carry_en, sr_val, reg_src;
  logic                ram_wr;
  logic                reg_d;

  assign ram_mode = cfg_q[RAM_BIT];
  assign carry_en = cfg_q[CY_BIT];
  assign sr_val   = cfg_q[POL_BIT];
  assign reg_src  = cfg_q[SRC_BIT];
  assign ram_wr   = ram_mode & wr_en & ~cfg_en;

  lutblk_cfg_chain #(.CFG_BITS(CFG_BITS), .IDX_W(IDX_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .shift_en(cfg_en), .shift_in(cfg_sin),
    .wr_req(ram_wr), .wr_addr(din), .wr_data(byp_d),
    .cfg_q(cfg_q), .shift_out(cfg_sout)
  );

  lutblk_func #(.IDX_W(IDX_W)) u_func (
    .table_bits(cfg_q[TBL-1:0]), .sel(din), .carry_en(carry_en),
    .cin(carry_in), .y(y), .cout(carry_out)
  );

  assign reg_d = reg_src ? byp_d : y;

  lutblk_ff u_ff (
    .clk(clk), .rst_n(rst_n), .sr(sr), .sr_val(sr_val), .d(reg_d), .q(yq)
  );

endmodule

// File: rtl/lutblk_checker.sv
module lutblk_checker #(
  parameter int IDX_W    = 4,
  parameter int CFG_BITS = 31
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_en,
  input logic                cfg_sin,
  input logic [CFG_BITS-1:0] cfg_q,
  input logic                cfg_sout,
  input logic                ram_wr,
  input logic [IDX_W-1:0]    din,
  input logic                byp_d,
  input logic                sr,
  input logic                sr_val,
  input logic                reg_src,
  input logic                carry_en,
  input logic                y,
  input logic                yq,
  input logic                carry_out
);

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (cfg_sout == $past(cfg_q[1])) && (cfg_q[CFG_BITS-1] == $past(cfg_sin))); // R2
  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !ram_wr) |=> $stable(cfg_q)); // R3
  AST_CARRY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_en |-> !carry_out); // R5
  AST_RAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |=> (cfg_q[$past(din)] == $past(byp_d))); // R6
  AST_SHIFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> !ram_wr); // R9
  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !sr |=> (yq == $past(reg_src ? byp_d : y))); // R7
  AST_SR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    sr |=> (yq == $past(sr_val))); // R8

endmodule

bind lut_logic_block lutblk_checker #(.IDX_W(IDX_W), .CFG_BITS(CFG_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_sin(cfg_sin), .cfg_q(cfg_q),
  .cfg_sout(cfg_sout), .ram_wr(ram_wr), .din(din), .byp_d(byp_d), .sr(sr),
  .sr_val(sr_val), .reg_src(reg_src), .carry_en(carry_en), .y(y), .yq(yq),
  .carry_out(carry_out)
);

// File: tb/lut_logic_block_bench.sv
module lut_logic_block_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] din = '0;
  logic       carry_in = 1'b0, sr = 1'b0, wr_en = 1'b0, byp_d = 1'b0;
  logic       cfg_en = 1'b0, cfg_sin = 1'b0;
  logic       cfg_sout, y, yq, carry_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [30:0] m_cfg = '0;

  always #4 clk = ~clk;

  lut_logic_block u_lut_logic_block (
    .clk(clk), .rst_n(rst_n), .din(din), .carry_in(carry_in), .sr(sr),
    .wr_en(wr_en), .byp_d(byp_d), .cfg_en(cfg_en), .cfg_sin(cfg_sin),
    .cfg_sout(cfg_sout), .y(y), .yq(yq), .carry_out(carry_out)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [30:0] mk(input logic [15:0] tbl, input logic ram,
      input logic cy, input logic pol, input logic src, input logic [10:0] rsv);
    return {rsv, src, pol, cy, ram, tbl};
  endfunction

  function automatic logic model_y(input logic [30:0] c, input logic [3:0] a, input logic ci);
    if (c[17]) return (a[0] + a[1] + ci) % 2 == 1;
    return (c[15:0] >> a) & 1'b1;
  endfunction

  function automatic logic model_co(input logic [30:0] c, input logic [3:0] a, input logic ci);
    if (!c[17]) return 1'b0;
    return (a[0] + a[1] + ci) >= 2;
  endfunction

  task automatic load_cfg(input logic [30:0] v);
    for (int i = 0; i < 31; i++) begin
      @(negedge clk);
      cfg_en = 1'b1; cfg_sin = v[i];
      @(posedge clk);
      m_cfg = {v[i], m_cfg[30:1]};
      #1;
      check(y, model_y(m_cfg, din, carry_in), "R10 y after shift");
    end
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic drain_check(input logic [30:0] v, input string tag);
    for (int i = 0; i < 31; i++) begin
      @(negedge clk);
      cfg_en = 1'b1; cfg_sin = 1'b0;
      #1;
      check(cfg_sout, v[i], tag);
      @(posedge clk);
    end
    @(negedge clk);
    cfg_en = 1'b0;
    m_cfg = '0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [15:0] tbls [4];
    logic [15:0] pat;
    logic [30:0] v;
    tbls[0] = 16'h8001; tbls[1] = 16'h6996; tbls[2] = 16'hA5C3; tbls[3] = 16'hFFFE;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(y, 1'b0, "R1 y");
    check(yq, 1'b0, "R1 yq");
    check(carry_out, 1'b0, "R1 carry_out");
    check(cfg_sout, 1'b0, "R1 cfg_sout");

    // R4 sweep over several truth tables
    for (int t = 0; t < 4; t++) begin
      load_cfg(mk(tbls[t], 0, 0, 0, 0, 11'h0));
      for (int a = 0; a < 16; a++) begin
        @(negedge clk); din = a[3:0]; #1;
        check(y, tbls[t][a], "R4 lut read");
        check(carry_out, 1'b0, "R5 carry off");
      end
    end

    // R2 / R3: load pattern with reserved bits, idle with toggling input, drain
    v = mk(16'h3A5C, 0, 0, 1, 0, 11'h5A3);
    load_cfg(v);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); cfg_sin = k[0];
    end
    drain_check(v, "R2 R3 serial readout");

    // R5 carry
    load_cfg(mk(16'h0000, 0, 1, 0, 0, 11'h0));
    for (int c = 0; c < 16; c++) begin
      @(negedge clk); din = {c[3], 1'b1, c[1], c[0]}; carry_in = c[2]; #1;
      check(y, model_y(m_cfg, din, carry_in), "R5 sum");
      check(carry_out, model_co(m_cfg, din, carry_in), "R5 carry");
    end
    carry_in = 1'b0;

    // R6 RAM mode writes and asynchronous read
    pat = 16'h3C5A;
    load_cfg(mk(16'h0000, 1, 0, 0, 0, 11'h0));
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); din = a[3:0]; byp_d = pat[a]; wr_en = 1'b1;
      @(posedge clk); #1;
      check(y, pat[a], "R6 read after write");
    end
    @(negedge clk); wr_en = 1'b0;
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); din = a[3:0]; #1;
      check(y, pat[a], "R6 ram contents");
    end

    // R9 shift together with a write: shift only
    m_cfg = {15'h0, 1'b1, pat};
    @(negedge clk); din = 4'd0; byp_d = ~pat[0]; wr_en = 1'b1; cfg_en = 1'b1; cfg_sin = 1'b1;
    @(posedge clk);
    m_cfg = {1'b1, m_cfg[30:1]};
    @(negedge clk); wr_en = 1'b0; cfg_en = 1'b0;
    drain_check(m_cfg, "R9 shift beats write");

    // R6 write enable ignored outside RAM mode
    load_cfg(mk(16'hF0F0, 0, 0, 0, 0, 11'h0));
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); din = a[3:0]; byp_d = ~a[4 - 0]; wr_en = 1'b1;
      byp_d = ~((16'hF0F0 >> a) & 1'b1);
      @(posedge clk);
    end
    @(negedge clk); wr_en = 1'b0;
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); din = a[3:0]; #1;
      check(y, (16'hF0F0 >> a) & 1'b1, "R6 wr_en ignored");
    end

    // R7 register source = LUT output
    load_cfg(mk(16'h6996, 0, 0, 0, 0, 11'h0));
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); din = a[3:0]; byp_d = ~16'h6996 >> a;
      @(posedge clk); #1;
      check(yq, (16'h6996 >> a) & 1'b1, "R7 yq from y");
    end
    // R7 register source = direct input
    load_cfg(mk(16'hFFFF, 0, 0, 0, 1, 11'h0));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); byp_d = k[0];
      @(posedge clk); #1;
      check(yq, k[0], "R7 yq from byp_d");
    end

    // R8 set/reset priority, both polarities
    @(negedge clk); byp_d = 1'b0; sr = 1'b1;
    load_cfg(mk(16'h0000, 0, 0, 1, 1, 11'h0));
    @(posedge clk); #1;
    check(yq, 1'b1, "R8 set wins over data 0");
    @(negedge clk); byp_d = 1'b1; sr = 1'b0;
    load_cfg(mk(16'h0000, 0, 0, 0, 1, 11'h0));
    @(negedge clk); sr = 1'b1;
    @(posedge clk); #1;
    check(yq, 1'b0, "R8 clear wins over data 1");
    @(negedge clk); sr = 1'b0;
    @(posedge clk); #1;
    check(yq, 1'b1, "R8 release follows data");

    report();
  end

endmodule